// File: doc/BRIEF.md
# Ready-Valid One-to-Two Dispatcher

This block sits between one upstream word source and a pair of downstream processing lanes. Every interface uses a valid/ready handshake. Each cycle it looks at which lanes can accept a word and steers the upstream word to one of them. Lane 0 is preferred whenever it is ready. The upstream side is told it may send whenever any lane is free.

The dispatcher is purely combinational, so a decision takes effect in the same cycle as the inputs that cause it. The word is broadcast unchanged on every lane's data bus. Only the per-lane valid tells a lane that the transfer belongs to it, so a word is never delivered twice. The lane count and data width are parameters, with defaults of two lanes and 16 bits. The lowest-numbered ready lane always wins.

Top module: `rvd_dispatch`

## Requirements
- R1: `up_ready` is high exactly when at least one bit of `dn_ready` is high.
- R2: When `dn_ready[0]` and `up_valid` are both high, `dn_valid[0]` is high, whatever the other lanes show.
- R3: `dn_valid[1]` is high only when `dn_ready[1]` is high and `dn_ready[0]` is low.
- R4: A lane's valid is never high unless that same lane's ready bit is high in that cycle.
- R5: No lane's valid is high while `up_valid` is low.
- R6: At most one bit of `dn_valid` is high in any cycle.
- R7: Every lane's data slice, `dn_data[16*i +: 16]` for lane i, always equals `up_data`.
- R8: When all `dn_ready` bits are low, `up_ready` is low and all `dn_valid` bits are low, for either value of `up_valid`.
- R9: On every clock edge where `up_valid` and `up_ready` are both high, exactly one lane's valid is high, and that lane's data slice equals `up_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| up_valid | input | 1 | Upstream has a word to offer |
| up_ready | output | 1 | Some lane can take the word |
| up_data | input | 16 | Upstream word |
| dn_ready | input | 2 | Per-lane accept indication, bit i for lane i |
| dn_valid | output | 2 | Per-lane ownership of the current word, bit i for lane i |
| dn_data | output | 32 | Per-lane data, lane i in bits [16*i +: 16] |

## Verification
On every cycle, the assertions check these invariants: a lane's valid never leads its ready, upstream valid gates every lane, at most one lane is selected, lane 0 wins a tie, and an all-busy cycle raises nothing. The bench's scenarios cover the rest. Its vector table goes through every combination of upstream valid and lane readiness against hand-derived outputs. Only the bench can show that data passes through unchanged on each lane. Only it can count each clock-edge transfer against the lane that received it.

// File: rtl/rvd_pkg.sv
package rvd_pkg;
    // Default geometry for the dispatcher
    localparam int unsigned RVD_DATA_W_DEF = 16;
    localparam int unsigned RVD_LANES_DEF  = 2;

    // Per-lane handshake pair seen by a lane slice
    typedef struct packed {
        logic valid;
        logic ready;
    } rvd_hs_t;
endpackage

// File: rtl/rvd_pick_first.sv
module rvd_pick_first #(
    parameter int unsigned LANES = rvd_pkg::RVD_LANES_DEF
) (
    input  logic [LANES-1:0] ready_i,
    output logic [LANES-1:0] grant_o,
    output logic             any_o
);
    logic taken;

    // Lowest-index ready lane wins
    always_comb begin
        taken = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            grant_o[i] = ready_i[i] & ~taken;
            taken      = taken | ready_i[i];
        end
    end

    assign any_o = taken;

    always_comb begin
        assert_grant_single_R6: assert ($onehot0(grant_o));
        assert_lane0_first_R2: assert (!ready_i[0] || grant_o[0]);
    end
endmodule

// File: rtl/rvd_lane.sv
module rvd_lane #(
    parameter int unsigned DATA_W = rvd_pkg::RVD_DATA_W_DEF
) (
    input  logic              grant_i,
    input  logic              up_valid_i,
    input  logic [DATA_W-1:0] up_data_i,
    input  logic              dn_ready_i,
    output logic              dn_valid_o,
    output logic [DATA_W-1:0] dn_data_o
);
    rvd_pkg::rvd_hs_t hs;

    assign hs.ready   = dn_ready_i;
    assign hs.valid   = grant_i & up_valid_i;
    assign dn_valid_o = hs.valid;
    assign dn_data_o  = up_data_i;

    always_comb begin
        assert_valid_after_ready_R4: assert (!hs.valid || hs.ready);
        assert_gated_by_up_R5: assert (!dn_valid_o || up_valid_i);
    end
endmodule

// File: rtl/rvd_dispatch.sv
module rvd_dispatch #(
    parameter int unsigned DATA_W = rvd_pkg::RVD_DATA_W_DEF,
    parameter int unsigned LANES  = rvd_pkg::RVD_LANES_DEF
) (
    input  logic                    up_valid,
    output logic                    up_ready,
    input  logic [DATA_W-1:0]       up_data,
    input  logic [LANES-1:0]        dn_ready,
    output logic [LANES-1:0]        dn_valid,
    output logic [LANES*DATA_W-1:0] dn_data
);
    logic [LANES-1:0] grant;

    rvd_pick_first #(.LANES(LANES)) u_pick (
        .ready_i (dn_ready),
        .grant_o (grant),
        .any_o   (up_ready)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rvd_lane #(.DATA_W(DATA_W)) u_lane (
            .grant_i    (grant[g]),
            .up_valid_i (up_valid),
            .up_data_i  (up_data),
            .dn_ready_i (dn_ready[g]),
            .dn_valid_o (dn_valid[g]),
            .dn_data_o  (dn_data[g*DATA_W +: DATA_W])
        );
    end

    always_comb begin
        assert_idle_quiet_R8: assert (dn_ready != '0 || (!up_ready && dn_valid == '0));
        assert_one_owner_R6: assert ($countones(dn_valid) <= 1);
        assert_accept_any_R1: assert (!up_ready || dn_ready != '0);
    end

    if (LANES >= 2) begin : g_second_chk
        always_comb begin
            assert_lane1_only_R3: assert (!dn_valid[1] || (dn_ready[1] && !dn_ready[0]));
        end
    end
endmodule

// File: tb/rvd_dispatch_bench.sv
module rvd_dispatch_bench;
    localparam int W = 16;
    localparam int L = 2;

    logic           clk = 1'b0;
    logic           up_valid;
    logic           up_ready;
    logic [W-1:0]   up_data;
    logic [L-1:0]   dn_ready;
    logic [L-1:0]   dn_valid;
    logic [L*W-1:0] dn_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;  // 4 ns period

    rvd_dispatch u_rvd_dispatch (
        .up_valid (up_valid),
        .up_ready (up_ready),
        .up_data  (up_data),
        .dn_ready (dn_ready),
        .dn_valid (dn_valid),
        .dn_data  (dn_data)
    );

    // {exp up_ready, exp v1, exp v0, up_valid, r1, r0, data}
    localparam logic [21:0] VEC [16] = '{
        {3'b000, 3'b000, 16'h1234}, {3'b100, 3'b001, 16'hABCD},
        {3'b100, 3'b010, 16'h0F0F}, {3'b100, 3'b011, 16'hFFFF},
        {3'b000, 3'b100, 16'h5555}, {3'b101, 3'b101, 16'hAAAA},
        {3'b110, 3'b110, 16'h0001}, {3'b101, 3'b111, 16'h8000},
        {3'b101, 3'b111, 16'hC3C3}, {3'b110, 3'b110, 16'h7E7E},
        {3'b101, 3'b101, 16'h0000}, {3'b000, 3'b100, 16'hDEAD},
        {3'b100, 3'b011, 16'hBEEF}, {3'b100, 3'b010, 16'h2468},
        {3'b100, 3'b001, 16'h1357}, {3'b000, 3'b000, 16'hFACE}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_data(input string req);
        for (int i = 0; i < L; i++)
            check(req, dn_data[i*W +: W], up_data);
    endtask

    // R9: each accepted transfer lands on exactly one lane with the same word
    always @(posedge clk) begin
        if (!done && up_valid && up_ready) begin
            check("R9 owners", W'($countones(dn_valid)), W'(1));
            for (int i = 0; i < L; i++)
                if (dn_valid[i]) check("R9 data", dn_data[i*W +: W], up_data);
        end
    end

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        up_valid = 1'b0;
        dn_ready = '0;
        up_data  = '0;
        @(negedge clk); #1;
        // Quiet start: nothing offered, nothing ready (R8)
        check("R8 start ready", W'(up_ready), W'(0));
        check("R8 start valid", W'(dn_valid), W'(0));

        // Table walk: R1, R2, R3, R4, R5, R6, R8
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            up_valid = VEC[k][18];
            dn_ready = VEC[k][17:16];
            up_data  = VEC[k][15:0];
            #1;
            check("R1 up_ready", W'(up_ready), W'(VEC[k][21]));
            check("R2 R3 R4 R5 valids", W'(dn_valid), W'(VEC[k][20:19]));
            check_data("R7 table");
        end

        // R7: walking one through the word with no lane ready
        for (int b = 0; b < W; b++) begin
            @(negedge clk);
            up_valid = 1'b1;
            dn_ready = '0;
            up_data  = W'(1) << b;
            #1;
            check_data("R7 walk");
            check("R8 busy valid", W'(dn_valid), W'(0));
        end

        // R2: tie held while data changes, lane 0 keeps ownership
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            up_valid = 1'b1;
            dn_ready = 2'b11;
            up_data  = W'(16'h1111 * (j + 1));
            #1;
            check("R2 tie", W'(dn_valid), W'(2'b01));
        end

        // R3: lane 0 drops, lane 1 takes over in the same cycle
        @(negedge clk);
        dn_ready = 2'b10;
        #1;
        check("R3 handover", W'(dn_valid), W'(2'b10));

        // R5: upstream withdraws while lanes stay ready
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check("R5 withdrawn", W'(dn_valid), W'(0));
        check("R1 still ready", W'(up_ready), W'(1));

        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule